// File: doc/BRIEF.md
# Operand Addressing-Mode Decoder

This block turns the 6-bit operand selector of a 16-bit instruction into a resolved operand. Each selector names exactly one kind of operand: a general register read directly, a memory word (addressed indirectly through a register, through a register plus a fetched offset, through the stack pointer, or through a fetched absolute address), one of the stack pointer, program counter or overflow register used directly, or an immediate value. Immediates are either a short literal held in the selector itself or a full word fetched after the instruction. Selectors that yield immediates are flagged as literals, so that the write-back stage discards any result aimed at them.

The decoder also works out the pointer side effects of the selector. Pop and push move the stack pointer. Modes that consume a following word advance the program counter and add one cycle. When the instruction is being skipped, only the advance past a following word remains. The caller supplies the register file contents, SP, PC, the overflow register and the word at PC. One cycle after a valid request, it gets back a registered result with the kind, the register index, the value or the effective address, and the update strobes. All address and pointer arithmetic wraps modulo 2^16.

Top module: `operand_decoder`

## Requirements
- R1: After reset, and in any cycle following one with valid_i low, all outputs are zero. Every result appears on the outputs exactly one clock after the cycle where valid_i was high, and valid_o marks it.
- R2: Selectors 0x00-0x07 give kind_o=0 (register), reg_idx_o = selector bits [2:0] (0=A, 1=B, 2=C, 3=X, 4=Y, 5=Z, 6=I, 7=J), and value_o = that register. Register n occupies regs_i[16n+15:16n].
- R3: Selectors 0x08-0x0F give kind_o=1 (memory), mem_o=1, and addr_o = the register named by selector bits [2:0], with no PC change and no extra cycle.
- R4: Selectors 0x10-0x17 give kind_o=1, addr_o = next_word_i + register (mod 2^16), pc_wr_o=1, pc_next_o = pc_i+1 (mod 2^16), and extra_cycle_o=1.
- R5: 0x18 (pop) gives memory at sp_i, sp_wr_o=1 and sp_next_o=sp_i+1. 0x19 (peek) gives memory at sp_i with sp_wr_o=0. 0x1A (push) gives memory at sp_i-1, sp_wr_o=1 and sp_next_o=sp_i-1. All of these wrap modulo 2^16.
- R6: 0x1B gives kind_o=2 with value_o=sp_i. 0x1C gives kind_o=3 with value_o=pc_i. 0x1D gives kind_o=4 with value_o=ovf_i. None of them accesses memory.
- R7: 0x1E gives kind_o=1 with addr_o=next_word_i. 0x1F gives kind_o=5 (immediate) with value_o=next_word_i. Both assert pc_wr_o, pc_next_o=pc_i+1 and extra_cycle_o.
- R8: Selectors 0x20-0x3F give kind_o=5 with value_o = selector & 0x1F (0 to 31), and no pointer change.
- R9: literal_o is 1 exactly when the decoded selector is 0x1F or above, whether or not the instruction is skipped.
- R10: With skip_i=1, kind_o=6 (none), and mem_o, sp_wr_o, extra_cycle_o, value_o and addr_o are 0. pc_wr_o=1 with pc_next_o=pc_i+1 only for 0x10-0x17, 0x1E and 0x1F.
- R11: Whenever a strobe (pc_wr_o, sp_wr_o) is 0, its matching next-value output is 0. Outside memory kind, mem_o and addr_o are 0, and reg_idx_o is 0 outside register kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Decode request this cycle |
| skip_i | input | 1 | Instruction is being skipped |
| sel_i | input | 6 | Operand selector |
| regs_i | input | 128 | Eight general registers, register n at bits 16n+15:16n |
| sp_i | input | 16 | Current stack pointer |
| pc_i | input | 16 | Current program counter (points at the next word) |
| ovf_i | input | 16 | Overflow register |
| next_word_i | input | 16 | Memory word at pc_i |
| valid_o | output | 1 | Result valid |
| kind_o | output | 3 | 0 reg, 1 mem, 2 SP, 3 PC, 4 overflow, 5 immediate, 6 none |
| reg_idx_o | output | 3 | Register index for register kind |
| value_o | output | 16 | Operand value for register, special and immediate kinds |
| addr_o | output | 16 | Effective memory address |
| literal_o | output | 1 | Operand is a literal, writes must be discarded |
| mem_o | output | 1 | Operand is a memory access |
| sp_wr_o | output | 1 | SP update strobe |
| sp_next_o | output | 16 | New SP value |
| pc_wr_o | output | 1 | PC update strobe |
| pc_next_o | output | 16 | New PC value |
| extra_cycle_o | output | 1 | One extra cycle consumed |

## Verification
The hardest behaviour to reach is the wrap of the pointers and the addresses at the ends of the 16-bit space. Examples are a push with SP at zero, a pop with SP at 0xFFFF, an indexed sum that carries out, and a word fetch with PC at 0xFFFF. Random values almost never land there, so directed vectors place SP, PC, the offset and the register at those edges. The skip path is also reached deliberately. Skip is combined with every selector class, to show that the PC still advances past a following word and that the stack pointer stays untouched. A random stream covers the rest, with skip and valid toggled freely.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
  localparam int SEL_W = 6;

  typedef enum logic [2:0] {
    KIND_REG  = 3'd0,
    KIND_MEM  = 3'd1,
    KIND_SP   = 3'd2,
    KIND_PC   = 3'd3,
    KIND_OVF  = 3'd4,
    KIND_IMM  = 3'd5,
    KIND_NONE = 3'd6
  } opnd_kind_e;

  typedef enum logic [3:0] {
    MODE_REG,
    MODE_IND,
    MODE_IDX,
    MODE_POP,
    MODE_PEEK,
    MODE_PUSH,
    MODE_SP,
    MODE_PC,
    MODE_OVF,
    MODE_ABS,
    MODE_NWLIT,
    MODE_SLIT
  } opnd_mode_e;
endpackage

// File: rtl/opnd_sel_class.sv
module opnd_sel_class
  import opnd_pkg::*;
#(
  parameter int REG_IDX_W = 3
) (
  input  logic [SEL_W-1:0]     sel_i,
  output opnd_mode_e           mode_o,
  output logic [REG_IDX_W-1:0] reg_idx_o,
  output logic                 next_word_o,
  output logic                 literal_o
);
  always_comb begin
    reg_idx_o = sel_i[REG_IDX_W-1:0];
    mode_o    = MODE_SLIT;
    if (sel_i[5]) begin
      mode_o = MODE_SLIT;
    end else begin
      unique case (sel_i[4:3])
        2'b00: mode_o = MODE_REG;
        2'b01: mode_o = MODE_IND;
        2'b10: mode_o = MODE_IDX;
        default: begin
          unique case (sel_i[2:0])
            3'd0: mode_o = MODE_POP;
            3'd1: mode_o = MODE_PEEK;
            3'd2: mode_o = MODE_PUSH;
            3'd3: mode_o = MODE_SP;
            3'd4: mode_o = MODE_PC;
            3'd5: mode_o = MODE_OVF;
            3'd6: mode_o = MODE_ABS;
            default: mode_o = MODE_NWLIT;
          endcase
        end
      endcase
    end
  end

  assign next_word_o = (mode_o == MODE_IDX) || (mode_o == MODE_ABS) ||
                       (mode_o == MODE_NWLIT);
  // 0x1F and every short literal
  assign literal_o   = (sel_i >= SEL_W'(6'h1F));
endmodule

// File: rtl/opnd_reg_mux.sv
module opnd_reg_mux #(
  parameter int DATA_W    = 16,
  parameter int NUM_REGS  = 8,
  parameter int REG_IDX_W = 3
) (
  input  logic [NUM_REGS*DATA_W-1:0] regs_i,
  input  logic [REG_IDX_W-1:0]       idx_i,
  output logic [DATA_W-1:0]          val_o
);
  logic [DATA_W-1:0] reg_arr [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_unpack
    assign reg_arr[g] = regs_i[g*DATA_W +: DATA_W];
  end

  assign val_o = reg_arr[idx_i];
endmodule

// File: rtl/opnd_ptr_upd.sv
module opnd_ptr_upd
  import opnd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  opnd_mode_e        mode_i,
  input  logic              skip_i,
  input  logic              next_word_i,
  input  logic [DATA_W-1:0] sp_i,
  input  logic [DATA_W-1:0] pc_i,
  output logic [DATA_W-1:0] stack_addr_o,
  output logic              sp_wr_o,
  output logic [DATA_W-1:0] sp_next_o,
  output logic              pc_wr_o,
  output logic [DATA_W-1:0] pc_next_o
);
  logic [DATA_W-1:0] sp_inc, sp_dec;

  assign sp_inc = sp_i + DATA_W'(1);
  assign sp_dec = sp_i - DATA_W'(1);

  // push addresses the pre-decremented slot
  assign stack_addr_o = (mode_i == MODE_PUSH) ? sp_dec : sp_i;

  always_comb begin
    sp_wr_o   = 1'b0;
    sp_next_o = '0;
    if (!skip_i) begin
      if (mode_i == MODE_POP) begin
        sp_wr_o   = 1'b1;
        sp_next_o = sp_inc;
      end else if (mode_i == MODE_PUSH) begin
        sp_wr_o   = 1'b1;
        sp_next_o = sp_dec;
      end
    end
  end

  // a following word is consumed even when skipping
  assign pc_wr_o   = next_word_i;
  assign pc_next_o = next_word_i ? (pc_i + DATA_W'(1)) : '0;
endmodule

// File: rtl/operand_decoder.sv
module operand_decoder
  import opnd_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_REGS  = 8,
  parameter int REG_IDX_W = $clog2(NUM_REGS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic                       skip_i,
  input  logic [5:0]                 sel_i,
  input  logic [NUM_REGS*DATA_W-1:0] regs_i,
  input  logic [DATA_W-1:0]          sp_i,
  input  logic [DATA_W-1:0]          pc_i,
  input  logic [DATA_W-1:0]          ovf_i,
  input  logic [DATA_W-1:0]          next_word_i,
  output logic                       valid_o,
  output logic [2:0]                 kind_o,
  output logic [REG_IDX_W-1:0]       reg_idx_o,
  output logic [DATA_W-1:0]          value_o,
  output logic [DATA_W-1:0]          addr_o,
  output logic                       literal_o,
  output logic                       mem_o,
  output logic                       sp_wr_o,
  output logic [DATA_W-1:0]          sp_next_o,
  output logic                       pc_wr_o,
  output logic [DATA_W-1:0]          pc_next_o,
  output logic                       extra_cycle_o
);
  localparam int SLIT_W = SEL_W - 1;

  opnd_mode_e           mode;
  logic [REG_IDX_W-1:0] ridx;
  logic                 uses_nw, is_lit;
  logic [DATA_W-1:0]    reg_val, stack_addr;
  logic                 sp_wr_d, pc_wr_d;
  logic [DATA_W-1:0]    sp_next_d, pc_next_d;

  opnd_sel_class #(.REG_IDX_W(REG_IDX_W)) u_class (
    .sel_i       (sel_i),
    .mode_o      (mode),
    .reg_idx_o   (ridx),
    .next_word_o (uses_nw),
    .literal_o   (is_lit)
  );

  opnd_reg_mux #(
    .DATA_W    (DATA_W),
    .NUM_REGS  (NUM_REGS),
    .REG_IDX_W (REG_IDX_W)
  ) u_rmux (
    .regs_i (regs_i),
    .idx_i  (ridx),
    .val_o  (reg_val)
  );

  opnd_ptr_upd #(.DATA_W(DATA_W)) u_ptr (
    .mode_i       (mode),
    .skip_i       (skip_i),
    .next_word_i  (uses_nw),
    .sp_i         (sp_i),
    .pc_i         (pc_i),
    .stack_addr_o (stack_addr),
    .sp_wr_o      (sp_wr_d),
    .sp_next_o    (sp_next_d),
    .pc_wr_o      (pc_wr_d),
    .pc_next_o    (pc_next_d)
  );

  opnd_kind_e           kind_d;
  logic [REG_IDX_W-1:0] ridx_d;
  logic [DATA_W-1:0]    value_d, addr_d;
  logic                 mem_d, extra_d;

  always_comb begin
    kind_d  = KIND_NONE;
    ridx_d  = '0;
    value_d = '0;
    addr_d  = '0;
    mem_d   = 1'b0;
    extra_d = 1'b0;
    if (!skip_i) begin
      extra_d = uses_nw;
      unique case (mode)
        MODE_REG: begin
          kind_d  = KIND_REG;
          ridx_d  = ridx;
          value_d = reg_val;
        end
        MODE_IND: begin
          kind_d = KIND_MEM;
          addr_d = reg_val;
        end
        MODE_IDX: begin
          kind_d = KIND_MEM;
          addr_d = next_word_i + reg_val;
        end
        MODE_POP, MODE_PEEK, MODE_PUSH: begin
          kind_d = KIND_MEM;
          addr_d = stack_addr;
        end
        MODE_SP: begin
          kind_d  = KIND_SP;
          value_d = sp_i;
        end
        MODE_PC: begin
          kind_d  = KIND_PC;
          value_d = pc_i;
        end
        MODE_OVF: begin
          kind_d  = KIND_OVF;
          value_d = ovf_i;
        end
        MODE_ABS: begin
          kind_d = KIND_MEM;
          addr_d = next_word_i;
        end
        MODE_NWLIT: begin
          kind_d  = KIND_IMM;
          value_d = next_word_i;
        end
        default: begin
          kind_d  = KIND_IMM;
          value_d = DATA_W'(sel_i[SLIT_W-1:0]);
        end
      endcase
      mem_d = (kind_d == KIND_MEM);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o       <= 1'b0;
      kind_o        <= '0;
      reg_idx_o     <= '0;
      value_o       <= '0;
      addr_o        <= '0;
      literal_o     <= 1'b0;
      mem_o         <= 1'b0;
      sp_wr_o       <= 1'b0;
      sp_next_o     <= '0;
      pc_wr_o       <= 1'b0;
      pc_next_o     <= '0;
      extra_cycle_o <= 1'b0;
    end else if (valid_i) begin
      valid_o       <= 1'b1;
      kind_o        <= kind_d;
      reg_idx_o     <= ridx_d;
      value_o       <= value_d;
      addr_o        <= addr_d;
      literal_o     <= is_lit;
      mem_o         <= mem_d;
      sp_wr_o       <= sp_wr_d;
      sp_next_o     <= sp_next_d;
      pc_wr_o       <= pc_wr_d;
      pc_next_o     <= pc_next_d;
      extra_cycle_o <= extra_d;
    end else begin
      valid_o       <= 1'b0;
      kind_o        <= '0;
      reg_idx_o     <= '0;
      value_o       <= '0;
      addr_o        <= '0;
      literal_o     <= 1'b0;
      mem_o         <= 1'b0;
      sp_wr_o       <= 1'b0;
      sp_next_o     <= '0;
      pc_wr_o       <= 1'b0;
      pc_next_o     <= '0;
      extra_cycle_o <= 1'b0;
    end
  end
endmodule

// File: rtl/operand_decoder_chk.sv
module operand_decoder_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              skip_i,
  input logic [5:0]        sel_i,
  input logic [DATA_W-1:0] sp_i,
  input logic [DATA_W-1:0] pc_i,
  input logic              valid_o,
  input logic [2:0]        kind_o,
  input logic [DATA_W-1:0] addr_o,
  input logic              literal_o,
  input logic              mem_o,
  input logic              sp_wr_o,
  input logic              pc_wr_o,
  input logic [DATA_W-1:0] pc_next_o,
  input logic              extra_cycle_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!sp_wr_o && !pc_wr_o && !mem_o && !literal_o));

  assert_literal_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (literal_o == ($past(sel_i) >= 6'h1F)));

  assert_peek_keeps_sp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !skip_i && sel_i == 6'h19) |=>
      (!sp_wr_o && mem_o && addr_o == $past(sp_i)));

  assert_indexed_fetch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !skip_i && sel_i[5:3] == 3'b010) |=>
      (pc_wr_o && extra_cycle_o && pc_next_o == $past(pc_i) + DATA_W'(1)));

  assert_skip_no_side_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && skip_i) |=>
      (kind_o == 3'd6 && !sp_wr_o && !mem_o && !extra_cycle_o));
endmodule

bind operand_decoder operand_decoder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .valid_i       (valid_i),
  .skip_i        (skip_i),
  .sel_i         (sel_i),
  .sp_i          (sp_i),
  .pc_i          (pc_i),
  .valid_o       (valid_o),
  .kind_o        (kind_o),
  .addr_o        (addr_o),
  .literal_o     (literal_o),
  .mem_o         (mem_o),
  .sp_wr_o       (sp_wr_o),
  .pc_wr_o       (pc_wr_o),
  .pc_next_o     (pc_next_o),
  .extra_cycle_o (extra_cycle_o)
);

// File: tb/sim_operand_decoder.sv
`timescale 1ns/1ps
module sim_operand_decoder;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0, skip_i = 1'b0;
  logic [5:0]   sel_i = '0;
  logic [127:0] regs_i = '0;
  logic [15:0]  sp_i = '0, pc_i = '0, ovf_i = '0, next_word_i = '0;
  logic         valid_o, literal_o, mem_o, sp_wr_o, pc_wr_o, extra_cycle_o;
  logic [2:0]   kind_o, reg_idx_o;
  logic [15:0]  value_o, addr_o, sp_next_o, pc_next_o;

  int n_chk = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  operand_decoder u0 (.*);

  // {valid,kind,idx,value,addr,literal,mem,sp_wr,sp_next,pc_wr,pc_next,extra}
  function automatic logic [75:0] expect_out(logic v, logic sk, logic [5:0] s,
      logic [127:0] rg, logic [15:0] sp, logic [15:0] pc, logic [15:0] ov,
      logic [15:0] nw);
    logic [2:0] k = 3'd0, ix = 3'd0;
    logic [15:0] val = '0, ad = '0, spn = '0, pcn = '0;
    logic lit, mem = 1'b0, spw = 1'b0, pcw = 1'b0, ex = 1'b0, fetch;
    logic [15:0] r = rg[s[2:0]*16 +: 16];
    if (!v) return '0;
    lit   = (s >= 6'h1F);
    fetch = (s[5:3] == 3'b010) || (s == 6'h1E) || (s == 6'h1F);
    if (fetch) begin pcw = 1'b1; pcn = pc + 16'd1; end
    if (sk) k = 3'd6;
    else begin
      ex = fetch;
      if (s < 6'h08) begin k = 3'd0; ix = s[2:0]; val = r; end
      else if (s < 6'h10) begin k = 3'd1; ad = r; end
      else if (s < 6'h18) begin k = 3'd1; ad = nw + r; end
      else if (s == 6'h18) begin k = 3'd1; ad = sp; spw = 1'b1; spn = sp + 16'd1; end
      else if (s == 6'h19) begin k = 3'd1; ad = sp; end
      else if (s == 6'h1A) begin k = 3'd1; ad = sp - 16'd1; spw = 1'b1; spn = sp - 16'd1; end
      else if (s == 6'h1B) begin k = 3'd2; val = sp; end
      else if (s == 6'h1C) begin k = 3'd3; val = pc; end
      else if (s == 6'h1D) begin k = 3'd4; val = ov; end
      else if (s == 6'h1E) begin k = 3'd1; ad = nw; end
      else if (s == 6'h1F) begin k = 3'd5; val = nw; end
      else begin k = 3'd5; val = {11'd0, s[4:0]}; end
      mem = (k == 3'd1);
    end
    return {1'b1, k, ix, val, ad, lit, mem, spw, spn, pcw, pcn, ex};
  endfunction

  function automatic string req_of(logic v, logic sk, logic [5:0] s);
    if (!v) return "R1";
    if (sk) return "R10";
    if (s < 6'h08) return "R2";
    if (s < 6'h10) return "R3";
    if (s < 6'h18) return "R4";
    if (s < 6'h1B) return "R5";
    if (s < 6'h1E) return "R6";
    if (s < 6'h20) return "R7";
    return "R8";
  endfunction

  function automatic logic [75:0] actual();
    return {valid_o, kind_o, reg_idx_o, value_o, addr_o, literal_o, mem_o,
            sp_wr_o, sp_next_o, pc_wr_o, pc_next_o, extra_cycle_o};
  endfunction

  task automatic check(string tag, logic [75:0] exp);
    logic [75:0] act = actual();
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s sel-related: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // also checks R9 (literal) and R11 (zeroed side fields) via full compare
  task automatic apply(logic v, logic sk, logic [5:0] s, logic [15:0] sp,
                       logic [15:0] pc, logic [15:0] nw);
    logic [75:0] exp;
    valid_i = v; skip_i = sk; sel_i = s; sp_i = sp; pc_i = pc; next_word_i = nw;
    exp = expect_out(v, sk, s, regs_i, sp, pc, ovf_i, nw);
    @(negedge clk_i);
    check(req_of(v, sk, s), exp);
  endtask

  initial begin
    void'($urandom(32'h0D0C_5EED));
    for (int i = 0; i < 8; i++) regs_i[i*16 +: 16] = 16'h1111 * (i + 1);
    ovf_i = 16'hBEEF;
    repeat (2) @(negedge clk_i);
    check("R1", '0); // reset state
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", '0);
    // directed corners
    for (int s = 0; s < 64; s++) apply(1'b1, 1'b0, 6'(s), 16'h4000, 16'h0100, 16'h0020);
    regs_i[2*16 +: 16] = 16'h0002;
    apply(1'b1, 1'b0, 6'h12, 16'h4000, 16'h0100, 16'hFFFF); // R4 index wrap
    apply(1'b1, 1'b0, 6'h1A, 16'h0000, 16'h0100, 16'h0);    // R5 push wrap
    apply(1'b1, 1'b0, 6'h18, 16'hFFFF, 16'h0100, 16'h0);    // R5 pop wrap
    apply(1'b1, 1'b0, 6'h19, 16'h0000, 16'h0100, 16'h0);    // R5 peek
    apply(1'b1, 1'b0, 6'h1F, 16'h1000, 16'hFFFF, 16'h1234); // R7 pc wrap, R9
    apply(1'b1, 1'b0, 6'h3F, 16'h1000, 16'h0010, 16'h0);    // R8 value 31
    apply(1'b1, 1'b1, 6'h1E, 16'h1000, 16'h0010, 16'h7777); // R10 pc advance
    apply(1'b1, 1'b1, 6'h18, 16'h1000, 16'h0010, 16'h0);    // R10 no sp change
    apply(1'b1, 1'b1, 6'h1A, 16'h1000, 16'h0010, 16'h0);    // R10
    apply(1'b1, 1'b1, 6'h15, 16'h1000, 16'h0010, 16'h0);    // R10
    apply(1'b1, 1'b1, 6'h25, 16'h1000, 16'h0010, 16'h0);    // R10 literal kept (R9)
    apply(1'b0, 1'b0, 6'h18, 16'h1000, 16'h0010, 16'h0);    // R1 idle
    // random stream
    for (int i = 0; i < 3000; i++) begin
      if (i % 97 == 0)
        for (int r = 0; r < 8; r++) regs_i[r*16 +: 16] = 16'($urandom);
      ovf_i = 16'($urandom);
      apply(($urandom % 8) != 0, ($urandom % 4) == 0, 6'($urandom),
            16'($urandom), 16'($urandom), 16'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule